// File: doc/BRIEF.md
# Programmable Frame Sync Detector

This block hunts for a 16-bit synchronisation word in a serial receive bit stream. The word lives in a run-time pattern register. A host writes that register as two bytes through a byte-wide stream port. When a load completes, the block reports that its buffer is free again and raises an interrupt.

Searching is armed by a separate command, never by a load. The command picks one of two modes. The strict mode needs a perfect match. The tolerant mode accepts up to a chosen number of disagreeing bits. On a match the block pulses a detect output and disarms itself.

Each valid received bit shifts into a 16-bit window. The block counts the disagreements between the window and the pattern and compares that count with the threshold latched by the search command.

The byte port uses valid/ready. A byte moves only on a cycle where `pat_valid` and `pat_ready` are both high. `pat_ready` is high only while a load is in progress. While `pat_valid` is high and `pat_ready` is low, the source must hold its byte and the block ignores it. The bit input has no back-pressure: every cycle with `rx_valid` high delivers a bit.

Top module: `fsync_hunter`

## Requirements
- R1: After reset, `buf_free` is 1, and `irq`, `pat_ready`, `hunting` and `found` are all 0.
- R2: A `load_go` pulse while `msg_busy` is 0 and `buf_free` is 1 starts a load. On the next cycle `buf_free` is 0 and `pat_ready` is 1. The first byte accepted is byte 0 and the second is byte 1. The cycle after the second byte is accepted, `buf_free` and `irq` are both 1 and `pat_ready` is 0. `irq` stays high until an `irq_ack` pulse.
- R3: A `load_go` pulse while `msg_busy` is 1 is ignored. `buf_free` stays 1, `pat_ready` stays 0, and the previous pattern stays in force.
- R4: Completing a load does not change `hunting`. Only a `hunt_go` pulse sets it.
- R5: Bit ordering: once 16 bits have arrived, the earliest of them is compared with bit 7 of byte 0 and the latest with bit 0 of byte 1.
- R6: `found` cannot assert until at least 16 bits with `rx_valid` high have arrived since the last `hunt_go`. A bit that arrives in the same cycle as `hunt_go` enters the window but is not counted.
- R7: With `hunt_strict` = 1 at `hunt_go`, a match needs zero disagreeing bits.
- R8: With `hunt_strict` = 0 at `hunt_go`, a match is declared when the number of disagreeing bits is at most `err_limit` (0 to 3). That value is latched at `hunt_go`.
- R9: `found` is high for exactly the one cycle after the clock edge that takes the matching bit. `hunting` falls at that same edge, and no further `found` occurs until the next `hunt_go`.
- R10: A byte presented with `pat_valid` high while `pat_ready` is 0 has no effect on the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_valid | input | 1 | Pattern byte valid |
| pat_ready | output | 1 | Pattern byte accepted when high with valid |
| pat_data | input | 8 | Pattern byte |
| load_go | input | 1 | Pulse: start a pattern load |
| msg_busy | input | 1 | High while a message is being received; blocks loads |
| buf_free | output | 1 | Byte buffer free; high after a load completes |
| irq | output | 1 | Interrupt flag set on load completion |
| irq_ack | input | 1 | Pulse: clear irq |
| rx_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received bit |
| hunt_go | input | 1 | Pulse: arm the search |
| hunt_strict | input | 1 | 1 selects the zero-error mode |
| err_limit | input | 2 | Tolerant mode mismatch limit |
| hunting | output | 1 | Search armed |
| found | output | 1 | One-cycle match pulse |

## Verification
The assertions assume that `load_go`, `hunt_go` and `irq_ack` are single-cycle pulses. They also assume that `pat_data` is held while `pat_valid` waits on a low `pat_ready`.

The stimulus drives each command for exactly one cycle and raises `pat_valid` only for the bytes it intends to deliver. It never pulses `hunt_go` in the same cycle as `rx_valid`. This keeps the bit count of R6 unambiguous for the reference model.

Random patterns are mixed with streams that plant the pattern with 0 to 4 flipped bits. This exercises both sides of each threshold.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  localparam int SYNC_W = 16;
  localparam int BYTE_W = 8;
  localparam int LIM_W  = 2;
  localparam int CNT_W  = $clog2(SYNC_W + 1);
  typedef logic [SYNC_W-1:0] sync_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/fsync_loader.sv
module fsync_loader
  import fsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_go,
  input  logic              msg_busy,
  input  logic              pat_valid,
  input  logic [BYTE_W-1:0] pat_data,
  input  logic              irq_ack,
  output logic              pat_ready,
  output logic              buf_free,
  output logic              irq,
  output sync_t             pattern
);
  logic              loading;
  logic              second;
  logic [BYTE_W-1:0] first_byte;
  logic              take;

  assign take      = loading && pat_valid;
  assign pat_ready = loading;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading    <= 1'b0;
      second     <= 1'b0;
      first_byte <= '0;
      buf_free   <= 1'b1;
      irq        <= 1'b0;
      pattern    <= '0;
    end else begin
      if (irq_ack) irq <= 1'b0;
      if (load_go && !msg_busy && !loading) begin
        loading  <= 1'b1;
        second   <= 1'b0;
        buf_free <= 1'b0;
      end else if (take) begin
        if (!second) begin
          first_byte <= pat_data;
          second     <= 1'b1;
        end else begin
          // byte 0 sits in the upper half: its MSB meets the earliest bit
          pattern  <= {first_byte, pat_data};
          loading  <= 1'b0;
          second   <= 1'b0;
          buf_free <= 1'b1;
          irq      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsync_correlator.sv
module fsync_correlator
  import fsync_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_valid,
  input  logic  rx_bit,
  input  sync_t pattern,
  output cnt_t  miss_next
);
  sync_t window;
  sync_t win_next;
  sync_t diff;

  assign win_next = {window[SYNC_W-2:0], rx_bit};
  assign diff     = win_next ^ pattern;

  always_comb begin
    miss_next = '0;
    for (int i = 0; i < SYNC_W; i++) miss_next = miss_next + cnt_t'(diff[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) window <= '0;
    else if (rx_valid) window <= win_next;
  end
endmodule

// File: rtl/fsync_hunt_ctl.sv
module fsync_hunt_ctl
  import fsync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hunt_go,
  input  logic             hunt_strict,
  input  logic [LIM_W-1:0] err_limit,
  input  logic             rx_valid,
  input  cnt_t             miss_next,
  output logic             hunting,
  output logic             found
);
  cnt_t             seen;
  logic [LIM_W-1:0] limit;
  cnt_t             seen_next;
  logic             hit;

  assign seen_next = (seen == cnt_t'(SYNC_W)) ? seen : seen + 1'b1;
  assign hit = hunting && rx_valid && !hunt_go &&
               (seen_next == cnt_t'(SYNC_W)) && (miss_next <= cnt_t'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunting <= 1'b0;
      found   <= 1'b0;
      seen    <= '0;
      limit   <= '0;
    end else begin
      found <= hit;
      if (hunt_go) begin
        hunting <= 1'b1;
        seen    <= '0;
        limit   <= hunt_strict ? '0 : err_limit;
      end else if (hit) begin
        hunting <= 1'b0;
      end else if (hunting && rx_valid) begin
        seen <= seen_next;
      end
    end
  end
endmodule

// File: rtl/fsync_hunter.sv
module fsync_hunter
  import fsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pat_valid,
  output logic       pat_ready,
  input  logic [7:0] pat_data,
  input  logic       load_go,
  input  logic       msg_busy,
  output logic       buf_free,
  output logic       irq,
  input  logic       irq_ack,
  input  logic       rx_valid,
  input  logic       rx_bit,
  input  logic       hunt_go,
  input  logic       hunt_strict,
  input  logic [1:0] err_limit,
  output logic       hunting,
  output logic       found
);
  sync_t pattern;
  cnt_t  miss_next;

  fsync_loader u_load (
    .clk(clk), .rst_n(rst_n), .load_go(load_go), .msg_busy(msg_busy),
    .pat_valid(pat_valid), .pat_data(pat_data), .irq_ack(irq_ack),
    .pat_ready(pat_ready), .buf_free(buf_free), .irq(irq), .pattern(pattern)
  );

  fsync_correlator u_corr (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .pattern(pattern), .miss_next(miss_next)
  );

  fsync_hunt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .hunt_go(hunt_go), .hunt_strict(hunt_strict),
    .err_limit(err_limit), .rx_valid(rx_valid), .miss_next(miss_next),
    .hunting(hunting), .found(found)
  );
endmodule

// File: rtl/fsync_hunter_chk.sv
module fsync_hunter_chk (
  input logic clk,
  input logic rst_n,
  input logic pat_ready,
  input logic load_go,
  input logic msg_busy,
  input logic buf_free,
  input logic irq,
  input logic hunt_go,
  input logic hunting,
  input logic found
);
  assert_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pat_ready |-> !buf_free);
  assert_irq_with_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> buf_free);
  assert_load_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && msg_busy && buf_free) |=> (buf_free && !pat_ready));
  assert_arm_by_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hunting) |-> $past(hunt_go));
  assert_found_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !hunting);
  assert_found_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !hunt_go) |=> !found);
endmodule

bind fsync_hunter fsync_hunter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pat_ready(pat_ready), .load_go(load_go),
  .msg_busy(msg_busy), .buf_free(buf_free), .irq(irq), .hunt_go(hunt_go),
  .hunting(hunting), .found(found)
);

// File: tb/sim_fsync_hunter.sv
`timescale 1ns/1ps
module sim_fsync_hunter;
  localparam real HALF = 4.0;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pat_valid = 0, pat_ready, load_go = 0, msg_busy = 0, buf_free, irq, irq_ack = 0;
  logic [7:0] pat_data = 0;
  logic rx_valid = 0, rx_bit = 0, hunt_go = 0, hunt_strict = 0, hunting, found;
  logic [1:0] err_limit = 0;
  int checks = 0, errors = 0;

  logic [15:0] m_pat = 0, m_win = 0;
  int m_seen = 0, m_thr = 0;
  bit m_hunt = 0, m_strict = 0;

  always #(HALF) clk = ~clk;

  fsync_hunter u0 (.*);

  function automatic int popc(logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += v[i];
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_pat(logic [7:0] b0, logic [7:0] b1);
    bit was_hunt;
    was_hunt = hunting;
    @(negedge clk) load_go = 1;
    @(negedge clk) load_go = 0;
    chk("R2 buf_free", buf_free, 0);
    chk("R2 pat_ready", pat_ready, 1);
    pat_valid = 1; pat_data = b0;
    @(negedge clk) pat_data = b1;
    @(negedge clk) pat_valid = 0;
    chk("R2 buf_free done", buf_free, 1);
    chk("R2 irq", irq, 1);
    chk("R4 hunting", hunting, was_hunt);
    m_pat = {b0, b1};
    @(negedge clk) irq_ack = 1;
    @(negedge clk) irq_ack = 0;
    chk("R2 irq_ack", irq, 0);
  endtask

  task automatic arm(bit strict, logic [1:0] lim);
    @(negedge clk) begin hunt_go = 1; hunt_strict = strict; err_limit = lim; end
    @(negedge clk) hunt_go = 0;
    m_hunt = 1; m_seen = 0; m_strict = strict; m_thr = strict ? 0 : lim;
    chk("R4 armed", hunting, 1);
  endtask

  task automatic send_bit(bit b);
    bit exp;
    string tag;
    @(negedge clk) begin rx_valid = 1; rx_bit = b; end
    m_win = {m_win[14:0], b};
    exp = 0;
    tag = "R9";
    if (m_hunt) begin
      if (m_seen < 16) m_seen++;
      tag = (m_seen < 16) ? "R6" : (m_strict ? "R7" : "R8");
      if (m_seen == 16 && popc(m_win ^ m_pat) <= m_thr) begin
        exp = 1;
        m_hunt = 0;
      end
    end
    @(negedge clk) rx_valid = 0;
    chk(tag, found, exp);
    chk("R9 hunting", hunting, m_hunt);
  endtask

  task automatic send_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 buf_free", buf_free, 1);
    chk("R1 irq", irq, 0);
    chk("R1 pat_ready", pat_ready, 0);
    chk("R1 hunting", hunting, 0);
    chk("R1 found", found, 0);
    rst_n = 1;
    // R10: bytes offered while not ready must not land
    @(negedge clk) begin pat_valid = 1; pat_data = 8'hFF; end
    @(negedge clk) pat_valid = 0;
    // R5 directed: byte 0 MSB is the earliest bit
    load_pat(8'hA5, 8'h3C);
    arm(1, 2'd3);
    send_word(16'hA53C);
    chk("R5 order", m_hunt, 0);
    // reversed bit order must not match in strict mode
    arm(1, 0);
    for (int i = 0; i < 16; i++) send_bit(m_pat[i]);
    // R3: load while busy ignored, old pattern stays
    @(negedge clk) begin msg_busy = 1; load_go = 1; end
    @(negedge clk) load_go = 0;
    chk("R3 buf_free", buf_free, 1);
    chk("R3 pat_ready", pat_ready, 0);
    @(negedge clk) begin pat_valid = 1; pat_data = 8'h00; end
    @(negedge clk) begin pat_valid = 0; msg_busy = 0; end
    arm(1, 0);
    send_word(16'hA53C);
    chk("R3 old pattern kept", m_hunt, 0);
    // R6: early bits never match even when the window already does
    arm(0, 2'd3);
    repeat (15) send_bit(1'b0);
    send_word(16'hA53C);
    // random mix
    for (int it = 0; it < 60; it++) begin
      int flips;
      logic [15:0] w;
      load_pat(8'($urandom), 8'($urandom));
      arm(1'($urandom), 2'($urandom));
      repeat ($urandom_range(0, 20)) send_bit(1'($urandom));
      w = m_pat;
      flips = $urandom_range(0, 4);
      for (int k = 0; k < flips; k++) w[$urandom_range(0, 15)] ^= 1'b1;
      send_word(w);
      repeat ($urandom_range(0, 8)) send_bit(1'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule